// File: doc/BRIEF.md
# Fractional Phase-Step Synthesizer Channel

This block is one output channel of a digital frequency synthesizer. It runs on a VCO-rate clock and treats each VCO period as 32 equal phase steps. The distance from one output edge to the next is a coarse count plus a fine fraction: `32 + md` whole steps plus `pe/32768` of a step. A running position register advances by that amount at every edge. The channel reports each edge as a one-cycle tick in the VCO cycle that contains the edge, together with the 5-bit phase-step index of the edge inside that cycle. An analog phase interpolator, outside this block, turns the tick and index into a real edge.

The edge stream then drives two post-dividers. The first is a power-of-two divider of `2^sdiv`. The second is an optional divide-by-3 stage that is active when its control bit is low. Together they produce a one-cycle enable at the start of each divided output period and a divided output level. The configuration arrives already committed from a register bank.

All parameters are resampled only at safe boundaries. The position step is taken at each edge, and the post-divider settings are taken at the start of each divided period. This lets a running clock be retuned without a short or malformed period.

Top module: `fsyn_channel`

## Requirements
- R1: Edge k lies at position P(k) = sum of the steps of edges 0..k-1. Positions are in units of 2^-20 VCO cycle, and a step is `((32+md) << 15) + pe`. `tick_o` is high for exactly the clock cycles whose index (counted from the first active cycle, index 0) equals `P(k) >> 20`, so ticks are never more than 2 cycles apart.
- R2: In a tick cycle, `phase_o` equals bits [19:15] of `P(k)` (the whole phase step inside the cycle). It is 0 in every cycle without a tick.
- R3: `md_i` and `pe_i` are sampled only in tick cycles. A change in any other cycle leaves the next tick's cycle and phase unchanged.
- R4: `div_en_o` is high only with a tick. It is high on the first tick after start and then on every N-th tick, where N = `2^sdiv * ns`.
- R5: The divide-by-3 control `div3_n_i` sets ns. A value of 0 gives ns = 3 and a value of 1 gives ns = 1.
- R6: `lvl_o` is sampled on ticks; j is the tick's index inside its divided period. With ns = 3, `lvl_o` is high for j < N/3 (1:2 duty). With ns = 1 and sdiv ≥ 1, it is high for j < N/2. With ns = 1 and sdiv = 0, it is high on every tick.
- R7: `sdiv_i` and `div3_n_i` are sampled only on the tick that starts a divided period. A change mid-period lets the current period finish at its old length.
- R8: When `md_i`, `pe_i` and `sdiv_i` are all zero, the channel is unprogrammed. It then gives no tick, no enable and a low level.
- R9: While `stby_n` = 0 or `ch_rst_n` = 0, all outputs stay 0. On release, the first active cycle carries a tick with phase 0 and an enable, and both dividers start from zero.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | VCO-rate clock |
| rst_n | input | 1 | Asynchronous-free synchronous system reset, active low |
| ch_rst_n | input | 1 | Channel reset, active low |
| stby_n | input | 1 | Channel run control, 0 = standby |
| md_i | input | 5 | Coarse step offset above 32 phase steps |
| pe_i | input | 15 | Fine step fraction in 1/32768 of a phase step |
| sdiv_i | input | 4 | Power-of-two post-divide exponent |
| div3_n_i | input | 1 | 0 = divide-by-3 active, 1 = bypass |
| tick_o | output | 1 | Edge present in this VCO cycle |
| phase_o | output | 5 | Phase-step index of the edge |
| div_en_o | output | 1 | Start of a divided output period |
| lvl_o | output | 1 | Divided output level |

## Verification
A corrupted position register shows up as a shifted phase index on the very next tick. It then shows as a tick landing one cycle early or late within two cycles. The bench compares against absolute edge positions, so such drift never cancels. A wrong post-divider count or latched setting shows within one divided period, as an enable on the wrong tick or as a level change at the wrong tick index. Settings changed mid-period expose any sampling outside the boundary on the very next enable.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;

  // Step between edges, in units of 2^-fr_w phase step:
  // (2^ph_w + md) whole steps followed by the fraction pe.
  function automatic logic [31:0] fs_step(input logic [31:0] md,
                                          input logic [31:0] pe,
                                          input int unsigned ph_w,
                                          input int unsigned fr_w);
    return (((32'd1 << ph_w) + md) << fr_w) | pe;
  endfunction

  // Window length of the power-of-two divider for exponent s.
  function automatic logic [31:0] fs_win(input logic [31:0] s);
    return 32'd1 << s;
  endfunction

endpackage

// File: rtl/fsyn_phase_acc.sv
module fsyn_phase_acc
  import fsyn_pkg::*;
#(
  parameter int PH_W = 5,
  parameter int FR_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PH_W-1:0] md,
  input  logic [FR_W-1:0] pe,
  output logic            tick,
  output logic [PH_W-1:0] phase,
  output logic [1:0]      gap_nxt
);
  localparam int ACC_W = PH_W + FR_W;
  localparam int SUM_W = ACC_W + 2;

  logic [ACC_W-1:0] acc_q;
  logic [1:0]       gap_q;
  logic [SUM_W-1:0] sum;
  logic [31:0]      step32;

  always_comb begin
    step32  = fs_step(32'(md), 32'(pe), PH_W, FR_W);
    sum     = SUM_W'(acc_q) + SUM_W'(step32);
    gap_nxt = sum[SUM_W-1:ACC_W];
  end

  assign tick  = run && (gap_q == 2'd1);
  assign phase = tick ? acc_q[ACC_W-1 -: PH_W] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      acc_q <= '0;
      gap_q <= 2'd1;
    end else if (tick) begin
      acc_q <= sum[ACC_W-1:0];
      gap_q <= gap_nxt;
    end else begin
      gap_q <= gap_q - 2'd1;
    end
  end

endmodule

// File: rtl/fsyn_post_div.sv
module fsyn_post_div
  import fsyn_pkg::*;
#(
  parameter int SD_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic [SD_W-1:0] sdiv,
  input  logic            div3_n,
  output logic            start,
  output logic            level,
  output logic [SD_W-1:0] win_sdiv,
  output logic            win_div3
);
  localparam int SC_W = (1 << SD_W) - 1;

  logic [SC_W-1:0] scnt_q;
  logic [1:0]      d3_q;
  logic [SD_W-1:0] s_q;
  logic            d3m_q;
  logic [SD_W-1:0] eff_s;
  logic            eff_d3;
  logic [SC_W:0]   win_len;
  logic            s_last;
  logic            s_wrap;
  logic            half_lo;

  always_comb begin
    start   = tick && (scnt_q == '0) && (d3_q == 2'd0);
    eff_s   = start ? sdiv : s_q;
    eff_d3  = start ? !div3_n : d3m_q;
    win_len = (SC_W+1)'(fs_win(32'(eff_s)));
    s_last  = ({1'b0, scnt_q} == (win_len - 1'b1));
    s_wrap  = tick && s_last;
    half_lo = (s_q != '0) && ((scnt_q >> (s_q - 1'b1)) == '0);
    if (!run)
      level = 1'b0;
    else if (eff_d3)
      level = (d3_q == 2'd0);
    else
      level = start || half_lo;
  end

  assign win_sdiv = s_q;
  assign win_div3 = d3m_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      scnt_q <= '0;
      d3_q   <= 2'd0;
      s_q    <= '0;
      d3m_q  <= 1'b0;
    end else begin
      if (start) begin
        s_q   <= sdiv;
        d3m_q <= !div3_n;
      end
      if (tick)
        scnt_q <= s_last ? '0 : scnt_q + 1'b1;
      if (s_wrap && eff_d3)
        d3_q <= (d3_q == 2'd2) ? 2'd0 : d3_q + 2'd1;
    end
  end

endmodule

// File: rtl/fsyn_channel.sv
module fsyn_channel #(
  parameter int PH_W = 5,
  parameter int FR_W = 15,
  parameter int SD_W = 4
) (
  input  logic            clk_vco,
  input  logic            rst_n,
  input  logic            ch_rst_n,
  input  logic            stby_n,
  input  logic [PH_W-1:0] md_i,
  input  logic [FR_W-1:0] pe_i,
  input  logic [SD_W-1:0] sdiv_i,
  input  logic            div3_n_i,
  output logic            tick_o,
  output logic [PH_W-1:0] phase_o,
  output logic            div_en_o,
  output logic            lvl_o
);
  logic            prog_w;
  logic            run_w;
  logic [1:0]      gap_nxt_w;
  logic [SD_W-1:0] win_sdiv_w;
  logic            win_div3_w;

  assign prog_w = (|md_i) || (|pe_i) || (|sdiv_i);
  assign run_w  = rst_n && ch_rst_n && stby_n && prog_w;

  fsyn_phase_acc #(.PH_W(PH_W), .FR_W(FR_W)) u_acc (
    .clk     (clk_vco),
    .rst_n   (rst_n),
    .run     (run_w),
    .md      (md_i),
    .pe      (pe_i),
    .tick    (tick_o),
    .phase   (phase_o),
    .gap_nxt (gap_nxt_w)
  );

  fsyn_post_div #(.SD_W(SD_W)) u_pdiv (
    .clk      (clk_vco),
    .rst_n    (rst_n),
    .run      (run_w),
    .tick     (tick_o),
    .sdiv     (sdiv_i),
    .div3_n   (div3_n_i),
    .start    (div_en_o),
    .level    (lvl_o),
    .win_sdiv (win_sdiv_w),
    .win_div3 (win_div3_w)
  );

endmodule

// File: rtl/fsyn_channel_chk.sv
module fsyn_channel_chk #(
  parameter int PH_W = 5,
  parameter int SD_W = 4
) (
  input logic            clk_vco,
  input logic            rst_n,
  input logic            ch_rst_n,
  input logic            stby_n,
  input logic            run_w,
  input logic            tick_o,
  input logic [PH_W-1:0] phase_o,
  input logic            div_en_o,
  input logic            lvl_o,
  input logic [1:0]      gap_nxt_w,
  input logic [SD_W-1:0] win_sdiv_w,
  input logic            win_div3_w
);
  // R1: never two consecutive tickless cycles while running
  p_gap_bound_r1: assert property (@(posedge clk_vco) disable iff (!rst_n || !run_w)
    !$past(tick_o) |-> tick_o);

  // R1: the carry that schedules the next edge is one or two cycles
  p_carry_range_r1: assert property (@(posedge clk_vco) disable iff (!rst_n)
    tick_o |-> (gap_nxt_w == 2'd1 || gap_nxt_w == 2'd2));

  // R2: phase index is zero away from a tick
  p_phase_idle_r2: assert property (@(posedge clk_vco) disable iff (!rst_n)
    !tick_o |-> (phase_o == '0));

  // R4: a divided-period start coincides with an edge
  p_en_on_tick_r4: assert property (@(posedge clk_vco) disable iff (!rst_n)
    div_en_o |-> tick_o);

  // R7: latched post-divider settings move only at a period start
  p_hold_window_r7: assert property (@(posedge clk_vco) disable iff (!rst_n || !run_w)
    ($past(run_w) && !$past(div_en_o)) |-> ($stable(win_sdiv_w) && $stable(win_div3_w)));

  // R9: standby or channel reset silences every output
  p_quiet_r9: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (!stby_n || !ch_rst_n) |-> (!tick_o && !div_en_o && !lvl_o));

  // R9: the first active cycle carries an edge at phase 0 and a period start
  p_restart_r9: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (run_w && !$past(run_w)) |-> (tick_o && phase_o == '0 && div_en_o));

endmodule

bind fsyn_channel fsyn_channel_chk #(.PH_W(PH_W), .SD_W(SD_W)) u_chk (
  .clk_vco    (clk_vco),
  .rst_n      (rst_n),
  .ch_rst_n   (ch_rst_n),
  .stby_n     (stby_n),
  .run_w      (run_w),
  .tick_o     (tick_o),
  .phase_o    (phase_o),
  .div_en_o   (div_en_o),
  .lvl_o      (lvl_o),
  .gap_nxt_w  (gap_nxt_w),
  .win_sdiv_w (win_sdiv_w),
  .win_div3_w (win_div3_w)
);

// File: tb/sim_fsyn_channel.sv
module sim_fsyn_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ch_rst_n = 1'b1;
  logic        stby_n = 1'b1;
  logic [4:0]  md = 5'd4;
  logic [14:0] pe = 15'h0100;
  logic [3:0]  sdiv = 4'd0;
  logic        d3n = 1'b1;
  logic        tick_o;
  logic [4:0]  phase_o;
  logic        div_en_o;
  logic        lvl_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fsyn_channel u0 (
    .clk_vco (clk), .rst_n (rst_n), .ch_rst_n (ch_rst_n), .stby_n (stby_n),
    .md_i (md), .pe_i (pe), .sdiv_i (sdiv), .div3_n_i (d3n),
    .tick_o (tick_o), .phase_o (phase_o), .div_en_o (div_en_o), .lvl_o (lvl_o)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic restart();
    @(negedge clk); stby_n = 1'b0;
    @(negedge clk); stby_n = 1'b1;
    #1;
  endtask

  // R10: outputs quiet under system reset
  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(tick_o == 1'b0, "R10 tick", tick_o, 0);
    chk(div_en_o == 1'b0, "R10 div_en", div_en_o, 0);
    chk(lvl_o == 1'b0, "R10 lvl", lvl_o, 0);
    chk(phase_o == 5'd0, "R10 phase", phase_o, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  // R1, R2, R3: edge cycles and phases from absolute positions
  task automatic t_stream(input logic [4:0] m0, input logic [14:0] p0, input int chg,
                          input logic [4:0] m1, input logic [14:0] p1, input int ncyc,
                          input string rq);
    longint pos;
    bit     et;
    md = m0; pe = p0; sdiv = 4'd0; d3n = 1'b1;
    @(negedge clk); stby_n = 1'b0;
    @(negedge clk); stby_n = 1'b1;
    pos = 0;
    for (int c = 0; c < ncyc; c++) begin
      if (c > 0) @(negedge clk);
      if (c == chg) begin md = m1; pe = p1; end
      #1;
      et = (longint'(c) == (pos >> 20));
      chk(tick_o == et, {rq, " R1 tick"}, tick_o, et);
      if (et) begin
        chk(phase_o == 5'((pos >> 15) & 31), {rq, " R2 phase"}, phase_o, (pos >> 15) & 31);
        pos += ((longint'(32) + longint'(md)) << 15) + longint'(pe);
      end else begin
        chk(phase_o == 5'd0, {rq, " R2 idle phase"}, phase_o, 0);
      end
    end
  endtask

  // R4, R5, R6, R7: post-divider enable and level per tick index
  task automatic t_post(input logic [3:0] s0, input logic dn, input int nt,
                        input int chg_k, input logic [3:0] s1, input string rq);
    int k, nstart, wstart, wn, j, cyc;
    bit wdiv3, ee, el, pend;
    md = 5'd9; pe = 15'h2222; sdiv = s0; d3n = dn;
    restart();
    k = 0; nstart = 0; wstart = 0; wn = 1; wdiv3 = 0; cyc = 0; pend = 0;
    while (k < nt && cyc < 4000) begin
      if (cyc > 0) begin
        @(negedge clk);
        if (pend) begin sdiv = s1; pend = 0; end
        #1;
      end
      cyc++;
      if (tick_o) begin
        ee = (k == nstart);
        if (ee) begin
          wdiv3 = !d3n;
          wn = (wdiv3 ? 3 : 1) << sdiv;
          wstart = k;
          nstart = k + wn;
        end
        j = k - wstart;
        if (wdiv3) el = (j < wn / 3);
        else if (wn == 1) el = 1'b1;
        else el = (j < wn / 2);
        chk(div_en_o == ee, {rq, " R4 enable"}, div_en_o, ee);
        chk(lvl_o == el, {rq, " R6 level"}, lvl_o, el);
        if (k == chg_k) pend = 1;
        k++;
      end else begin
        chk(div_en_o == 1'b0, {rq, " R4 idle enable"}, div_en_o, 0);
      end
    end
    chk(k == nt, {rq, " R4 tick count"}, k, nt);
  endtask

  // R8: all-zero settings mean no output
  task automatic t_unprog();
    md = 5'd0; pe = 15'd0; sdiv = 4'd0; d3n = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); #1;
      chk(tick_o == 1'b0 && div_en_o == 1'b0, "R8 no tick", tick_o, 0);
      chk(lvl_o == 1'b0, "R8 level low", lvl_o, 0);
    end
    @(negedge clk); sdiv = 4'd1; #1;
    chk(tick_o == 1'b1, "R8 programmed by sdiv alone", tick_o, 1);
  endtask

  // R9: standby and channel reset silence, then clean restart
  task automatic t_standby();
    md = 5'd2; pe = 15'h7000; sdiv = 4'd2; d3n = 1'b0;
    repeat (20) @(negedge clk);
    stby_n = 1'b0;
    for (int c = 0; c < 5; c++) begin
      #1;
      chk(!tick_o && !div_en_o && !lvl_o, "R9 standby quiet", {tick_o, div_en_o, lvl_o}, 0);
      @(negedge clk);
    end
    stby_n = 1'b1; #1;
    chk(tick_o && div_en_o && phase_o == 5'd0, "R9 standby restart",
        {tick_o, div_en_o, phase_o}, 64 + 32);
    repeat (7) @(negedge clk);
    ch_rst_n = 1'b0;
    for (int c = 0; c < 5; c++) begin
      #1;
      chk(!tick_o && !div_en_o && !lvl_o, "R9 channel reset quiet", {tick_o, div_en_o, lvl_o}, 0);
      @(negedge clk);
    end
    ch_rst_n = 1'b1; #1;
    chk(tick_o && div_en_o && phase_o == 5'd0 && lvl_o, "R9 reset restart",
        {tick_o, div_en_o, phase_o}, 64 + 32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stream(5'd5,  15'h1234, -1, 5'd0, 15'd0, 300, "R1 mid");
    t_stream(5'd31, 15'h7fff, -1, 5'd0, 15'd0, 300, "R1 max step");
    t_stream(5'd0,  15'd1,    -1, 5'd0, 15'd0, 200, "R1 min step");
    t_stream(5'd3,  15'h4000, 37, 5'd20, 15'd0, 300, "R3 change");
    t_post(4'd2, 1'b0, 60, -1, 4'd0, "R5 div3 sdiv2");
    t_post(4'd0, 1'b0, 30, -1, 4'd0, "R5 div3 sdiv0");
    t_post(4'd3, 1'b1, 40, -1, 4'd0, "R6 bypass sdiv3");
    t_post(4'd0, 1'b1, 20, -1, 4'd0, "R6 bypass sdiv0");
    t_post(4'd2, 1'b1, 20, 2, 4'd1, "R7 sdiv change");
    t_unprog();
    t_standby();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule